// File: doc/BRIEF.md
# Countdown Alarm Timer with Interrupt

This block is the relative alarm of a real-time clock. Software writes a remaining interval as packed day, hour, minute and second fields. While counting is switched on, every one-second tick pulse takes one second off the interval, with borrows carried across the mixed-radix fields. When the interval runs out, a sticky pending flag is raised, and an interrupt line follows that flag whenever the interrupt-enable bit is set.

Software reaches the block through a simple word-addressed write port and a combinational read port. There are four registers: the interval, a control word with the count-enable bit, an interrupt-enable word and a status word holding the pending flag. The pending flag is cleared by writing a one to it. The tick source and the calendar sit outside this block.

Top module: `cnt_alarm`

## Requirements
- R1: After reset the interval reads 0, count enable and interrupt enable read 0, pending reads 0 and `irq_o` is low.
- R2: A write to offset 0x0C loads the interval. Seconds go in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21, which allows up to 255 days. A read of 0x0C returns the same layout, with all other bits 0.
- R3: Bit 8 of offset 0x14 is the count enable. While it reads 0, ticks leave the interval unchanged and never raise pending.
- R4: A tick that arrives while counting is enabled and the interval is nonzero lowers the seconds by one. The result shows on the read port in the cycle after the tick edge.
- R5: When seconds are 0 on a tick, they reload to 59 and take one from minutes. Minutes at 0 reload to 59 and take one from hours. Hours at 0 reload to 23 and take one from days.
- R6: The tick that brings a nonzero interval to zero sets pending once. Later ticks leave the interval at zero and do not set pending again.
- R7: Writing zero to the interval clears any loaded count. An interval write in the same cycle as a tick wins over the decrement, and that cycle raises no pending.
- R8: Bit 0 of offset 0x1C reads the pending flag. Writing 1 to that bit clears pending and writing 0 has no effect. If an expiry and a clear fall in the same cycle, pending ends up set.
- R9: Bit 0 of offset 0x18 is the interrupt enable. `irq_o` is a registered output that always equals pending AND interrupt enable as seen on the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte offset of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Byte offset of the read |
| rd_data_o | output | DATA_W | Read data (combinational from register state) |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The countdown is driven with short intervals whose values are chosen to hit each borrow on its own: a bare seconds count, a minute with zero seconds, an hour with zero minutes and a day with zero hours. Any mistake in a reload constant or in the borrow chain then shows up as a distinct wrong read value. The block is also run with ticks while counting is disabled and with interval writes that coincide with a tick, which separates the gating path from the load-priority path. Further cases place a status clear on the same edge as an expiry and toggle the interrupt enable while pending is held, which tells the set/clear priority apart from the output gating. A long stretch with irregular tick spacing is compared on every cycle against a behavioural model.

// File: rtl/cnt_alarm_pkg.sv
package cnt_alarm_pkg;

    // field widths fixed by the time radix
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HR_W    = 5;

    // bit positions inside the interval word (decoded by software)
    localparam int SEC_LSB = 0;
    localparam int MIN_LSB = 8;
    localparam int HR_LSB  = 16;
    localparam int DAY_LSB = 21;

    // reload values on borrow
    localparam int SEC_TOP = 59;
    localparam int MIN_TOP = 59;
    localparam int HR_TOP  = 23;

    // register offsets and control bit positions
    localparam int OFF_IVAL = 'h0C;
    localparam int OFF_CTRL = 'h14;
    localparam int OFF_IEN  = 'h18;
    localparam int OFF_STS  = 'h1C;
    localparam int CNT_EN_BIT = 8;
    localparam int IEN_BIT    = 0;
    localparam int PEND_BIT   = 0;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } hms_t;

    typedef struct packed {
        logic cnt_en;
        logic irq_en;
    } ctl_t;

    typedef struct packed {
        logic pend;
        logic irq;
    } flag_t;

endpackage

// File: rtl/cnt_alarm_decode.sv
module cnt_alarm_decode
    import cnt_alarm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DAY_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              ld_o,
    output logic [DAY_W-1:0]  ld_day_o,
    output hms_t              ld_hms_o,
    output logic              sts_clr_o,
    output logic              cnt_en_o,
    output logic              irq_en_o,
    output logic              irq_en_nxt_o
);

    ctl_t ctl_d, ctl_q;
    logic hit_ival, hit_ctrl, hit_ien, hit_sts;
    logic unused_wr_bits;

    assign hit_ival = wr_en_i && (wr_addr_i == ADDR_W'(OFF_IVAL));
    assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(OFF_CTRL));
    assign hit_ien  = wr_en_i && (wr_addr_i == ADDR_W'(OFF_IEN));
    assign hit_sts  = wr_en_i && (wr_addr_i == ADDR_W'(OFF_STS));

    always_comb begin
        ctl_d = ctl_q;
        if (hit_ctrl) begin
            ctl_d.cnt_en = wr_data_i[CNT_EN_BIT];
        end
        if (hit_ien) begin
            ctl_d.irq_en = wr_data_i[IEN_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ld_o         = hit_ival;
    assign ld_day_o     = wr_data_i[DAY_LSB +: DAY_W];
    assign ld_hms_o.sc  = wr_data_i[SEC_LSB +: SEC_W];
    assign ld_hms_o.mn  = wr_data_i[MIN_LSB +: MIN_W];
    assign ld_hms_o.hr  = wr_data_i[HR_LSB +: HR_W];
    assign sts_clr_o    = hit_sts && wr_data_i[PEND_BIT];
    assign cnt_en_o     = ctl_q.cnt_en;
    assign irq_en_o     = ctl_q.irq_en;
    assign irq_en_nxt_o = ctl_d.irq_en;

    assign unused_wr_bits = ^wr_data_i;

endmodule

// File: rtl/cnt_alarm_dhms.sv
module cnt_alarm_dhms
    import cnt_alarm_pkg::*;
#(
    parameter int DAY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             cnt_en_i,
    input  logic             ld_i,
    input  logic [DAY_W-1:0] ld_day_i,
    input  hms_t             ld_hms_i,
    output logic [DAY_W-1:0] day_o,
    output hms_t             hms_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [DAY_W-1:0] day;
        hms_t             hms;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic is_zero;

    assign is_zero = (cnt_q == '0);

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (ld_i) begin
            cnt_d.day = ld_day_i;
            cnt_d.hms = ld_hms_i;
        end else if (tick_i && cnt_en_i && !is_zero) begin
            if (cnt_q.hms.sc != '0) begin
                cnt_d.hms.sc = cnt_q.hms.sc - SEC_W'(1);
            end else begin
                cnt_d.hms.sc = SEC_W'(SEC_TOP);
                if (cnt_q.hms.mn != '0) begin
                    cnt_d.hms.mn = cnt_q.hms.mn - MIN_W'(1);
                end else begin
                    cnt_d.hms.mn = MIN_W'(MIN_TOP);
                    if (cnt_q.hms.hr != '0) begin
                        cnt_d.hms.hr = cnt_q.hms.hr - HR_W'(1);
                    end else begin
                        cnt_d.hms.hr = HR_W'(HR_TOP);
                        cnt_d.day    = cnt_q.day - DAY_W'(1);
                    end
                end
            end
            expire_o = (cnt_d == '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign day_o = cnt_q.day;
    assign hms_o = cnt_q.hms;

endmodule

// File: rtl/cnt_alarm_flag.sv
module cnt_alarm_flag
    import cnt_alarm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic clr_i,
    input  logic irq_en_nxt_i,
    output logic pend_o,
    output logic irq_o
);

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (expire_i) begin
            flg_d.pend = 1'b1;
        end else if (clr_i) begin
            flg_d.pend = 1'b0;
        end
        flg_d.irq = flg_d.pend && irq_en_nxt_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign pend_o = flg_q.pend;
    assign irq_o  = flg_q.irq;

endmodule

// File: rtl/cnt_alarm.sv
module cnt_alarm
    import cnt_alarm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DAY_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    logic             wr_ival;
    logic [DAY_W-1:0] ld_day;
    hms_t             ld_hms;
    logic             sts_clr;
    logic             cnt_en;
    logic             irq_en;
    logic             irq_en_nxt;
    logic [DAY_W-1:0] ival_day;
    hms_t             ival_hms;
    logic             expire;
    logic             pend;

    cnt_alarm_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DAY_W  (DAY_W)
    ) u_decode (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .ld_o         (wr_ival),
        .ld_day_o     (ld_day),
        .ld_hms_o     (ld_hms),
        .sts_clr_o    (sts_clr),
        .cnt_en_o     (cnt_en),
        .irq_en_o     (irq_en),
        .irq_en_nxt_o (irq_en_nxt)
    );

    cnt_alarm_dhms #(
        .DAY_W (DAY_W)
    ) u_dhms (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .cnt_en_i (cnt_en),
        .ld_i     (wr_ival),
        .ld_day_i (ld_day),
        .ld_hms_i (ld_hms),
        .day_o    (ival_day),
        .hms_o    (ival_hms),
        .expire_o (expire)
    );

    cnt_alarm_flag u_flag (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .expire_i     (expire),
        .clr_i        (sts_clr),
        .irq_en_nxt_i (irq_en_nxt),
        .pend_o       (pend),
        .irq_o        (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(OFF_IVAL)) begin
            rd_data_o[SEC_LSB +: SEC_W] = ival_hms.sc;
            rd_data_o[MIN_LSB +: MIN_W] = ival_hms.mn;
            rd_data_o[HR_LSB +: HR_W]   = ival_hms.hr;
            rd_data_o[DAY_LSB +: DAY_W] = ival_day;
        end else if (rd_addr_i == ADDR_W'(OFF_CTRL)) begin
            rd_data_o[CNT_EN_BIT] = cnt_en;
        end else if (rd_addr_i == ADDR_W'(OFF_IEN)) begin
            rd_data_o[IEN_BIT] = irq_en;
        end else if (rd_addr_i == ADDR_W'(OFF_STS)) begin
            rd_data_o[PEND_BIT] = pend;
        end
    end

endmodule

// File: rtl/cnt_alarm_chk.sv
module cnt_alarm_chk
    import cnt_alarm_pkg::*;
#(
    parameter int DAY_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             wr_ival,
    input logic [DAY_W-1:0] ld_day,
    input hms_t             ld_hms,
    input logic             sts_clr,
    input logic             cnt_en,
    input logic             irq_en,
    input logic [DAY_W-1:0] ival_day,
    input hms_t             ival_hms,
    input logic             expire,
    input logic             pend,
    input logic             irq_o
);

    logic cnt_zero;
    assign cnt_zero = (ival_day == '0) && (ival_hms == '0);

    p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ival |=> (ival_day == $past(ld_day)) && (ival_hms == $past(ld_hms)));

    p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_en && !wr_ival) |=> ($stable(ival_day) && $stable(ival_hms)));

    p_sec_borrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cnt_en && !wr_ival && !cnt_zero && ival_hms.sc == '0)
        |=> (ival_hms.sc == SEC_W'(SEC_TOP)));

    p_zero_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_zero && !wr_ival) |=> cnt_zero);

    p_pend_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend) |-> cnt_zero);

    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_clr && !expire) |=> !pend);

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> pend);

    p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (pend && irq_en));

endmodule

bind cnt_alarm cnt_alarm_chk #(.DAY_W(DAY_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_ival  (wr_ival),
    .ld_day   (ld_day),
    .ld_hms   (ld_hms),
    .sts_clr  (sts_clr),
    .cnt_en   (cnt_en),
    .irq_en   (irq_en),
    .ival_day (ival_day),
    .ival_hms (ival_hms),
    .expire   (expire),
    .pend     (pend),
    .irq_o    (irq_o)
);

// File: tb/test_cnt_alarm.sv
`timescale 1ns/1ps
module test_cnt_alarm;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_IVAL = 5'h0C;
    localparam logic [AW-1:0] A_CTRL = 5'h14;
    localparam logic [AW-1:0] A_IEN  = 5'h18;
    localparam logic [AW-1:0] A_STS  = 5'h1C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_day = 0, m_hr = 0, m_mn = 0, m_sc = 0;
    bit m_en = 0, m_ien = 0, m_pend = 0, m_irq = 0;

    always #2 clk = ~clk;

    cnt_alarm i_cnt_alarm (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic [31:0] pack(int d, int h, int m, int s);
        return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] mread(logic [AW-1:0] a);
        if (a == A_IVAL) return pack(m_day, m_hr, m_mn, m_sc);
        if (a == A_CTRL) return 32'(m_en) << 8;
        if (a == A_IEN)  return 32'(m_ien);
        if (a == A_STS)  return 32'(m_pend);
        return 32'h0;
    endfunction

    task automatic model_edge(bit tk, bit we, logic [AW-1:0] wa, logic [31:0] wd);
        bit exp_hit = 0;
        if (we && wa == A_IVAL) begin
            m_sc = int'(wd[5:0]); m_mn = int'(wd[13:8]);
            m_hr = int'(wd[20:16]); m_day = int'(wd[28:21]);
        end else if (tk && m_en && (m_day + m_hr + m_mn + m_sc) != 0) begin
            if (m_sc > 0) m_sc--;
            else begin
                m_sc = 59;
                if (m_mn > 0) m_mn--;
                else begin
                    m_mn = 59;
                    if (m_hr > 0) m_hr--;
                    else begin m_hr = 23; m_day--; end
                end
            end
            exp_hit = (m_day + m_hr + m_mn + m_sc) == 0;
        end
        if (we && wa == A_CTRL) m_en = wd[8];
        if (we && wa == A_IEN)  m_ien = wd[0];
        if (exp_hit) m_pend = 1;
        else if (we && wa == A_STS && wd[0]) m_pend = 0;
        m_irq = m_pend && m_ien;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit tk, bit we, logic [AW-1:0] wa, logic [31:0] wd,
                        logic [AW-1:0] ra, string tag);
        tick = tk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        model_edge(tk, we, wa, wd);
        @(negedge clk);
        tick = 0; wr_en = 0;
        chk({tag, " read"}, rd_data, mread(ra));
        chk({tag, " irq R9"}, 32'(irq), 32'(m_irq));
    endtask

    task automatic wr(logic [AW-1:0] wa, logic [31:0] wd, string tag);
        step(0, 1, wa, wd, wa, tag);
    endtask

    task automatic tk(int n, logic [AW-1:0] ra, string tag);
        for (int i = 0; i < n; i++) step(1, 0, '0, '0, ra, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(0, 0, '0, '0, A_IVAL, "R1 ival");
        chk("R1 ival const", rd_data, 32'h0);
        step(0, 0, '0, '0, A_CTRL, "R1 ctrl");
        step(0, 0, '0, '0, A_IEN,  "R1 ien");
        step(0, 0, '0, '0, A_STS,  "R1 sts");
        chk("R1 irq low", 32'(irq), 32'h0);

        // R2 load and layout
        wr(A_IVAL, pack(1, 0, 0, 2), "R2 load");
        chk("R2 layout", rd_data, 32'h0020_0002);

        // R3 ticks while disabled
        tk(3, A_IVAL, "R3 frozen");
        chk("R3 unchanged", rd_data, 32'h0020_0002);

        // R4/R5 day borrow
        wr(A_CTRL, 32'h100, "R3 enable");
        wr(A_IEN, 32'h1, "R9 ien");
        tk(2, A_IVAL, "R4 dec");
        chk("R4 sec zero", rd_data, 32'h0020_0000);
        tk(1, A_IVAL, "R5 day borrow");
        chk("R5 day borrow", rd_data, 32'h0017_3B3B);

        wr(A_IVAL, pack(0, 0, 1, 0), "R5 load min");
        tk(1, A_IVAL, "R5 min borrow");
        chk("R5 min borrow", rd_data, 32'h0000_003B);
        wr(A_IVAL, pack(0, 1, 0, 0), "R5 load hr");
        tk(1, A_IVAL, "R5 hr borrow");
        chk("R5 hr borrow", rd_data, 32'h0000_3B3B);

        // R6 expiry once
        wr(A_IVAL, pack(0, 0, 0, 2), "R6 load");
        tk(2, A_STS, "R6 expire");
        chk("R6 pend set", rd_data, 32'h1);
        chk("R9 irq on", 32'(irq), 32'h1);
        tk(3, A_IVAL, "R6 stays zero");
        chk("R6 zero", rd_data, 32'h0);
        wr(A_STS, 32'h1, "R8 clear");
        chk("R8 cleared", rd_data, 32'h0);
        tk(3, A_STS, "R6 no reset");
        chk("R6 no second pend", rd_data, 32'h0);

        // R8 write zero no effect
        wr(A_IVAL, pack(0, 0, 0, 1), "R8 load");
        tk(1, A_STS, "R8 expire");
        wr(A_STS, 32'h0, "R8 w0");
        chk("R8 w0 keeps", rd_data, 32'h1);

        // R8 set wins over clear
        wr(A_STS, 32'h1, "R8 clr");
        wr(A_IVAL, pack(0, 0, 0, 1), "R8 load2");
        step(1, 1, A_STS, 32'h1, A_STS, "R8 set wins");
        chk("R8 set wins", rd_data, 32'h1);

        // R9 gating
        wr(A_IEN, 32'h0, "R9 ien off");
        chk("R9 irq gated", 32'(irq), 32'h0);
        wr(A_IEN, 32'h1, "R9 ien on");
        chk("R9 irq back", 32'(irq), 32'h1);
        wr(A_STS, 32'h1, "R9 clr");

        // R7 zero write and load priority
        wr(A_IVAL, pack(0, 0, 0, 5), "R7 load");
        tk(1, A_IVAL, "R7 dec");
        wr(A_IVAL, 32'h0, "R7 zero");
        chk("R7 cleared", rd_data, 32'h0);
        tk(2, A_STS, "R7 no pend");
        chk("R7 no pend", rd_data, 32'h0);
        step(1, 1, A_IVAL, pack(0, 0, 0, 1), A_IVAL, "R7 load wins");
        chk("R7 load wins", rd_data, 32'h1);
        step(0, 0, '0, '0, A_STS, "R7 no pend2");
        chk("R7 no pend2", rd_data, 32'h0);

        // R3 disable mid count
        wr(A_CTRL, 32'h0, "R3 disable");
        tk(2, A_IVAL, "R3 hold");
        chk("R3 hold", rd_data, 32'h1);
        step(0, 0, '0, '0, A_STS, "R3 no pend");
        chk("R3 no pend", rd_data, 32'h0);

        // R2 max day
        wr(A_IVAL, pack(255, 23, 59, 59), "R2 max");
        chk("R2 max", rd_data, 32'h1FF7_3B3B);
        wr(A_CTRL, 32'h100, "R4 en");
        tk(1, A_IVAL, "R4 max dec");
        chk("R4 max dec", rd_data, 32'h1FF7_3B3A);

        // long irregular stretch against the model
        wr(A_IVAL, pack(0, 0, 3, 5), "R6 long load");
        begin
            logic [7:0] lf = 8'hA5;
            for (int i = 0; i < 600; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                step(lf[0], 0, '0, '0, (i % 2 == 0) ? A_IVAL : A_STS, "R6 stretch");
            end
        end
        chk("R6 long expired", 32'(m_pend), 32'h1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule